// File: doc/BRIEF.md
# Battery-Backed SRAM Chip-Enable Guard

This block sits between a host and a battery-backed static RAM. It passes the host's active-low chip enable to the memory while main power is healthy. It blocks memory access when power fails, but it lets an access that is already running finish first. It also picks which of two backup batteries feeds the memory and raises a warning when the battery in use is weak.

All analog sensing is done outside the block. The block sees the supply and battery comparators as clean, synchronous flags. A tolerance input selects which of two supply trip flags means "power good". A low battery is reported in two ways. One is a live warning flag. The other is a deliberate refusal of the second memory cycle after each power-up, so that software can find a weak battery with a write-then-read test.

After reset the block sits in a shipping state in which backup stays off. That state ends at the first power-up. Battery backup becomes active only when the supply later drops below the battery voltage.

Top module: `nvram_ce_guard`

## Requirements
- R1: While the selected power-good flag is 1, the block is out of the shipping state and no other blocking condition applies, `ce_n_out` equals `ce_n_in` in the same cycle, with no register in between.
- R2: With `tol_sel`=0, power-good is `sup_hi_ok`. With `tol_sel`=1, power-good is `sup_lo_ok`. The flag that is not selected has no effect on `ce_n_out`.
- R3: While power-good is 0, any host access that was not already running at the last clock edge is blocked, so `ce_n_out` is 1.
- R4: If `ce_n_in` was 0 at the last clock edge while power was good, and power-good then falls, `ce_n_out` follows `ce_n_in` (stays 0) until `ce_n_in` returns to 1. After that, new accesses stay blocked while power remains bad.
- R5: `bat_sel` is 0 (battery 1) when `bat1_gt_bat2`=1 or `bat2_gnd`=1. Otherwise it is 1 (battery 2).
- R6: `bat_warn` equals the low flag of the battery chosen by `bat_sel` (`bat1_low` for 0, `bat2_low` for 1). A grounded second battery therefore never raises the warning.
- R7: Power-up is a clock cycle in which power-good is 1 after being 0 in the cycle before (or after reset). On that edge the block records whether the battery in use is low and restarts its count of host cycles, where each falling edge of `ce_n_in` starts a new cycle. If the battery was low, the second cycle is blocked (`ce_n_out`=1 for its whole duration). The first cycle and the third and later cycles pass.
- R8: From reset until the clock edge that ends the first power-up cycle, `ce_n_out` and `backup_on` are both held at 0.
- R9: Once out of the shipping state, `backup_on` is 1 exactly when `sup_above_bat` is 0. `ce_n_out` is 1 while `backup_on` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_in | input | 1 | Host chip enable, active low |
| sup_hi_ok | input | 1 | Supply above the higher trip point |
| sup_lo_ok | input | 1 | Supply above the lower trip point |
| tol_sel | input | 1 | Trip point select: 0 higher, 1 lower |
| bat1_low | input | 1 | Battery 1 below its threshold |
| bat2_low | input | 1 | Battery 2 below its threshold |
| bat2_gnd | input | 1 | Battery 2 input is grounded (not fitted) |
| bat1_gt_bat2 | input | 1 | Battery 1 voltage above battery 2 |
| sup_above_bat | input | 1 | Supply above the battery voltage |
| ce_n_out | output | 1 | Gated chip enable to the RAM, active low |
| backup_on | output | 1 | Battery backup active |
| bat_sel | output | 1 | Battery in use: 0 battery 1, 1 battery 2 |
| bat_warn | output | 1 | Battery in use is low |

## Verification
The checks assume that the comparator flags are already synchronised and only change between clock edges. They also assume that the host holds `ce_n_in` high in the cycle in which power-good rises, so a power-up never lands on a falling edge of the chip enable. The stimulus changes inputs just after a rising edge and, before every power-up, spends one cycle with the chip enable high. Supply flags are driven consistently: `sup_above_bat` is 0 only while power-good is also 0 after the shipping state has ended. This keeps the fail-time checks on the write block and on backup from contradicting each other.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    typedef enum logic {
        BAT_ONE = 1'b0,
        BAT_TWO = 1'b1
    } bat_e;

    typedef struct packed {
        logic hi_ok;
        logic lo_ok;
        logic above_bat;
    } supply_t;

    typedef struct packed {
        logic b1_low;
        logic b2_low;
        logic b2_gnd;
        logic b1_gt_b2;
    } battery_t;

    // Pick the trip flag selected by the tolerance input.
    function automatic logic pick_good(input logic tol, input supply_t s);
        return tol ? s.lo_ok : s.hi_ok;
    endfunction

endpackage

// File: rtl/nvc_power_gate.sv
module nvc_power_gate
    import nvc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n_in,
    input  logic    tol_sel,
    input  supply_t sup,
    output logic    pwr_good,
    output logic    pu_edge,
    output logic    seal,
    output logic    pass_ok
);

    logic pg_prev_q;
    logic hold_q;
    logic seal_q;

    assign pwr_good = pick_good(tol_sel, sup);
    assign pu_edge  = pwr_good & ~pg_prev_q;
    assign seal     = seal_q;
    // An access running since the last edge may finish after power drops.
    assign pass_ok  = pwr_good | (hold_q & ~ce_n_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            pg_prev_q <= 1'b0;
            hold_q    <= 1'b0;
            seal_q    <= 1'b1;
        end else begin
            pg_prev_q <= pwr_good;
            hold_q    <= ~ce_n_in & (pwr_good | hold_q);
            if (pu_edge) begin
                seal_q <= 1'b0;
            end
        end
    end

    // R8: once released, the shipping state never returns without reset
    p_seal_stays_open_r8: assert property (@(posedge clk) disable iff (rst)
        !seal_q |=> !seal_q);

    // R4: the in-flight hold drops once the host releases the enable
    p_hold_release_r4: assert property (@(posedge clk) disable iff (rst)
        (hold_q && ce_n_in) |=> !hold_q);

endmodule

// File: rtl/nvc_battery_sel.sv
module nvc_battery_sel
    import nvc_pkg::*;
(
    input  battery_t bat,
    output bat_e     sel,
    output logic     in_use_low
);

    always_comb begin
        sel = (bat.b1_gt_b2 || bat.b2_gnd) ? BAT_ONE : BAT_TWO;
        case (sel)
            BAT_ONE: in_use_low = bat.b1_low;
            default: in_use_low = bat.b2_low;
        endcase
    end

    // R6: a grounded second battery cannot raise the warning on its own
    always_comb begin
        if (bat.b2_gnd && !bat.b1_low) begin
            p_gnd_quiet_r6: assert (!in_use_low);
        end
    end

endmodule

// File: rtl/nvc_cycle_guard.sv
module nvc_cycle_guard #(
    parameter int CNT_W     = 2,
    parameter int BLOCK_IDX = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n_in,
    input  logic pu_edge,
    input  logic bat_low,
    output logic block
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] BLK     = CNT_W'(BLOCK_IDX);

    logic             ce_prev_q;
    logic [CNT_W-1:0] idx_q;
    logic             low_q;
    logic             fall;
    logic [CNT_W-1:0] idx_inc;
    logic [CNT_W-1:0] cur_idx;

    assign fall    = ce_prev_q & ~ce_n_in;
    assign idx_inc = (idx_q == CNT_MAX) ? idx_q : idx_q + 1'b1;
    assign cur_idx = fall ? idx_inc : idx_q;
    assign block   = low_q & ~ce_n_in & (cur_idx == BLK);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev_q <= 1'b1;
            idx_q     <= '0;
            low_q     <= 1'b0;
        end else begin
            ce_prev_q <= ce_n_in;
            if (pu_edge) begin
                idx_q <= '0;
                low_q <= bat_low;
            end else if (fall) begin
                idx_q <= idx_inc;
            end
        end
    end

    // R7: each power-up restarts the cycle count
    p_count_clear_r7: assert property (@(posedge clk) disable iff (rst)
        pu_edge |=> (idx_q == '0));

    // R7: the weak-battery verdict only changes on a power-up
    p_low_stable_r7: assert property (@(posedge clk) disable iff (rst)
        !pu_edge |=> $stable(low_q));

endmodule

// File: rtl/nvram_ce_guard.sv
module nvram_ce_guard
    import nvc_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int BLOCK_IDX = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n_in,
    input  logic sup_hi_ok,
    input  logic sup_lo_ok,
    input  logic tol_sel,
    input  logic bat1_low,
    input  logic bat2_low,
    input  logic bat2_gnd,
    input  logic bat1_gt_bat2,
    input  logic sup_above_bat,
    output logic ce_n_out,
    output logic backup_on,
    output logic bat_sel,
    output logic bat_warn
);

    supply_t  sup;
    battery_t bat;
    bat_e     sel;
    logic     pwr_good;
    logic     pu_edge;
    logic     seal;
    logic     pass_ok;
    logic     in_use_low;
    logic     block2;

    assign sup = '{hi_ok: sup_hi_ok, lo_ok: sup_lo_ok, above_bat: sup_above_bat};
    assign bat = '{b1_low: bat1_low, b2_low: bat2_low, b2_gnd: bat2_gnd,
                   b1_gt_b2: bat1_gt_bat2};

    nvc_power_gate u_pwr (
        .clk      (clk),
        .rst      (rst),
        .ce_n_in  (ce_n_in),
        .tol_sel  (tol_sel),
        .sup      (sup),
        .pwr_good (pwr_good),
        .pu_edge  (pu_edge),
        .seal     (seal),
        .pass_ok  (pass_ok)
    );

    nvc_battery_sel u_bat (
        .bat        (bat),
        .sel        (sel),
        .in_use_low (in_use_low)
    );

    nvc_cycle_guard #(
        .CNT_W     (CNT_W),
        .BLOCK_IDX (BLOCK_IDX)
    ) u_cyc (
        .clk     (clk),
        .rst     (rst),
        .ce_n_in (ce_n_in),
        .pu_edge (pu_edge),
        .bat_low (in_use_low),
        .block   (block2)
    );

    assign backup_on = ~seal & ~sup.above_bat;
    assign bat_sel   = sel;
    assign bat_warn  = in_use_low;

    always_comb begin
        if (seal) begin
            ce_n_out = 1'b0;
        end else if (backup_on || !pass_ok || block2) begin
            ce_n_out = 1'b1;
        end else begin
            ce_n_out = ce_n_in;
        end
    end

    // R3: a failed supply with the host idle at the last edge blocks access
    p_fail_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!seal && !pwr_good && $past(!pwr_good) && $past(ce_n_in)) |-> ce_n_out);

    // R9: no access reaches the RAM during backup
    p_backup_high_r9: assert property (@(posedge clk) disable iff (rst)
        backup_on |-> ce_n_out);

endmodule

// File: tb/tb_nvram_ce_guard.sv
`timescale 1ns/1ps
module tb_nvram_ce_guard;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n_in = 1'b1, sup_hi_ok = 1'b0, sup_lo_ok = 1'b0, tol_sel = 1'b0;
    logic bat1_low = 1'b0, bat2_low = 1'b0, bat2_gnd = 1'b0, bat1_gt_bat2 = 1'b1;
    logic sup_above_bat = 1'b0;
    logic ce_n_out, backup_on, bat_sel, bat_warn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    nvram_ce_guard dut (
        .clk(clk), .rst(rst), .ce_n_in(ce_n_in), .sup_hi_ok(sup_hi_ok),
        .sup_lo_ok(sup_lo_ok), .tol_sel(tol_sel), .bat1_low(bat1_low),
        .bat2_low(bat2_low), .bat2_gnd(bat2_gnd), .bat1_gt_bat2(bat1_gt_bat2),
        .sup_above_bat(sup_above_bat), .ce_n_out(ce_n_out),
        .backup_on(backup_on), .bat_sel(bat_sel), .bat_warn(bat_warn)
    );

    // Row: req[16:13] ce tol hi lo b1gt gnd b1lo b2lo sab | ceo bk sel warn
    localparam int NROW = 14;
    localparam logic [16:0] VEC [NROW] = '{
        17'b0001_0_0_1_1_1_0_0_0_1_0_0_0_0, // R1 pass low
        17'b0001_1_0_1_1_1_0_0_0_1_1_0_0_0, // R1 pass high
        17'b0010_0_0_0_1_1_0_0_0_1_1_0_0_0, // R2 tol 0 uses high trip
        17'b0010_0_1_0_1_1_0_0_0_1_0_0_0_0, // R2 tol 1 ignores high trip
        17'b0010_0_1_1_0_1_0_0_0_1_1_0_0_0, // R2 tol 1 uses low trip
        17'b0011_1_0_0_0_1_0_0_0_1_1_0_0_0, // R3 idle during fail
        17'b0101_0_0_1_1_0_0_0_1_1_0_0_1_1, // R5 battery 2 chosen, low
        17'b0110_0_0_1_1_0_0_1_0_1_0_0_1_0, // R6 unused battery 1 low
        17'b0110_0_0_1_1_1_0_1_0_1_0_0_0_1, // R6 battery 1 in use, low
        17'b0110_0_0_1_1_0_1_0_1_1_0_0_0_0, // R6 grounded battery 2 quiet
        17'b0101_0_0_1_1_0_1_1_1_1_0_0_0_1, // R5 grounded forces battery 1
        17'b1001_0_0_0_0_1_0_0_0_0_1_1_0_0, // R9 backup, access
        17'b1001_1_0_0_0_1_0_0_0_0_1_1_0_0, // R9 backup, idle
        17'b1001_0_1_0_0_1_0_0_0_1_1_0_0_0  // R9 fail above battery, no backup
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        @(negedge clk);
        got = {ce_n_out, backup_on, bat_sel, bat_warn};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {ce_n_out,backup_on,bat_sel,bat_warn} actual %b expected %b",
                     tag, got, exp);
        end
    endtask

    task automatic idle();
        ce_n_in = 1'b1; tol_sel = 1'b0; sup_hi_ok = 1'b1; sup_lo_ok = 1'b1;
        bat1_gt_bat2 = 1'b1; bat2_gnd = 1'b0; bat1_low = 1'b0; bat2_low = 1'b0;
        sup_above_bat = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8: shipping state holds outputs low before any power-up
        chk("R8 reset state", 4'b0000);
        tick(); ce_n_in = 1'b0;
        chk("R8 seal ignores host", 4'b0000);
        tick(); ce_n_in = 1'b1; sup_hi_ok = 1'b1; sup_lo_ok = 1'b1; sup_above_bat = 1'b1;
        chk("R8 seal held in power-up cycle", 4'b0000);
        tick();
        chk("R8 seal released after power-up", 4'b1000);
        tick(); sup_hi_ok = 1'b0; sup_lo_ok = 1'b0; sup_above_bat = 1'b0;
        chk("R9 backup after seal exit", 4'b1100);

        // table walk, each row preceded by one idle cycle with power good
        for (int i = 0; i < NROW; i++) begin
            tick(); idle();
            tick();
            {ce_n_in, tol_sel, sup_hi_ok, sup_lo_ok, bat1_gt_bat2, bat2_gnd,
             bat1_low, bat2_low, sup_above_bat} = VEC[i][12:4];
            chk($sformatf("R%0d table row %0d", VEC[i][16:13], i), VEC[i][3:0]);
        end

        // R4: an access running when power fails completes
        tick(); idle();
        tick(); ce_n_in = 1'b0;
        tick(); sup_hi_ok = 1'b0; sup_lo_ok = 1'b0;
        chk("R4 in-flight kept at fail", 4'b0000);
        tick();
        chk("R4 in-flight still kept", 4'b0000);
        tick(); ce_n_in = 1'b1;
        chk("R4 released access", 4'b1000);
        tick(); ce_n_in = 1'b0;
        chk("R4 new access blocked", 4'b1000);

        // R7: weak battery 1 at power-up blocks only the second cycle
        tick(); ce_n_in = 1'b1; bat1_low = 1'b1;
        tick(); sup_hi_ok = 1'b1; sup_lo_ok = 1'b1;
        tick(); ce_n_in = 1'b0;
        chk("R7 first cycle passes", 4'b0001);
        tick(); ce_n_in = 1'b1;
        tick(); ce_n_in = 1'b0;
        chk("R7 second cycle blocked", 4'b1001);
        tick();
        chk("R7 second cycle stays blocked", 4'b1001);
        tick(); ce_n_in = 1'b1;
        tick(); ce_n_in = 1'b0;
        chk("R7 third cycle passes", 4'b0001);

        // R6 R7: grounded low battery 2 does not block the second cycle
        tick(); ce_n_in = 1'b1; sup_hi_ok = 1'b0; sup_lo_ok = 1'b0;
        bat1_low = 1'b0; bat2_low = 1'b1; bat2_gnd = 1'b1; bat1_gt_bat2 = 1'b0;
        tick(); sup_hi_ok = 1'b1; sup_lo_ok = 1'b1;
        tick(); ce_n_in = 1'b0;
        chk("R6 grounded first cycle", 4'b0000);
        tick(); ce_n_in = 1'b1;
        tick(); ce_n_in = 1'b0;
        chk("R7 grounded second cycle passes", 4'b0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule